// File: doc/BRIEF.md
# Word-Write Bit-Serial-Read Buffer

This block is a single-clock memory written one complete word per clock and read back as a serial bit stream. A write stores a whole word into one location of an internal array. A read starts with a one-cycle strobe that carries a word address. The addressed word is fetched whole into a shift register. The register then moves right once per clock with zero fill, and its bit 0 is the serial output. The word therefore leaves least significant bit first.

The read path has a fixed schedule. The RAM read is registered, so the shift register loads one clock after the strobe is accepted. The first bit is presented in the cycle that follows that load. A bit counter ends the run after exactly `WIDTH` bits and raises a one-cycle completion pulse. Only one read is in flight at a time. A strobe is accepted when the block is idle, and the completion cycle counts as idle.

Top module: `bitserial_word_buf`

## Requirements
- R1: When `wr_en` is high at a rising clock edge, the full `wr_data` word is stored at `wr_addr` in that single clock. A later read of that address returns the word.
- R2: A `rd_start` sampled while `busy` is low is accepted. `busy` is high, and `bit_valid` low, in the cycle after the accepting edge (the fetch cycle). `bit_valid` rises in the cycle after that.
- R3: Once `bit_valid` rises, it stays high for exactly `WIDTH` consecutive cycles. In the k-th of those cycles (k counted from 0), `ser_bit` equals bit k of the stored word, so bit 0 comes first.
- R4: `done` is high for exactly one cycle, the cycle right after the last valid bit. In that cycle `busy` and `bit_valid` are low, and a `rd_start` there is accepted.
- R5: Whenever `bit_valid` is low, `ser_bit` is 0, because zeros shift in at the most significant end.
- R6: A `rd_start` sampled while `busy` is high is ignored. The current bit stream is not changed, and no further read follows it.
- R7: A write to the address being read does not change the bits of that read. This holds both for a write during the run and for a write at the same edge as the accepting strobe, which reads the old word. The new word is returned by the next read.
- R8: Synchronous active-high `rst` clears the shift register, the bit counter, `bit_valid`, `busy` and `done`. The RAM contents are kept.
- R9: `WIDTH` (default 10) sets the word width and `DEPTH` (default 256) sets the word count. The address width is derived as ceil(log2(`DEPTH`)).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Store `wr_data` at `wr_addr` |
| wr_addr | input | AW | Write word address |
| wr_data | input | WIDTH | Word to store |
| rd_start | input | 1 | One-cycle strobe that starts a serial read |
| rd_addr | input | AW | Word address for the read, sampled with `rd_start` |
| ser_bit | output | 1 | Serial data, bit 0 of the shift register |
| bit_valid | output | 1 | `ser_bit` carries a word bit this cycle |
| busy | output | 1 | A read is being fetched or shifted |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The checker watches several properties on every cycle. Valid bits only appear while busy. An accepted strobe is followed by a fetch cycle. `done` is a single pulse, and it lands after a run of exactly `WIDTH` valid cycles. The serial output is zero outside the valid window.

Some behaviour depends on data and history, so only the bench scenarios can show it. These are the bit order against stored words, the retention of RAM contents across reset, and the immunity of an in-flight word to writes to its own address. The bench also shows that a strobe while busy leaves no pending read behind.

// File: rtl/bswb_pkg.sv
package bswb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SHIFT = 2'd2
    } rd_state_e;

endpackage

// File: rtl/bswb_ram.sv
module bswb_ram #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 256,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Whole-word write, registered whole-word read (old data on collision).
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/bswb_ctrl.sv
module bswb_ctrl #(
    parameter int WIDTH = 10,
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] word_in,
    output logic             fetch_en,
    output logic             ser_bit,
    output logic             bit_valid,
    output logic             busy,
    output logic             done
);
    import bswb_pkg::*;

    typedef struct packed {
        rd_state_e        state;
        logic [WIDTH-1:0] shreg;
        logic [CW-1:0]    cnt;
        logic             done;
    } ctrl_t;

    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        fetch_en  = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (start) begin
                    fetch_en   = 1'b1;
                    st_d.state = ST_FETCH;
                end
            end
            ST_FETCH: begin
                st_d.shreg = word_in;
                st_d.cnt   = '0;
                st_d.state = ST_SHIFT;
            end
            ST_SHIFT: begin
                st_d.shreg = {1'b0, st_q.shreg[WIDTH-1:1]};
                if (st_q.cnt == LAST) begin
                    st_d.state = ST_IDLE;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{state: ST_IDLE, shreg: '0, cnt: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_bit   = st_q.shreg[0];
    assign bit_valid = (st_q.state == ST_SHIFT);
    assign busy      = (st_q.state != ST_IDLE);
    assign done      = st_q.done;

endmodule

// File: rtl/bitserial_word_buf.sv
module bitserial_word_buf #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 256,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_start,
    input  logic [AW-1:0]    rd_addr,
    output logic             ser_bit,
    output logic             bit_valid,
    output logic             busy,
    output logic             done
);

    logic             fetch_en;
    logic [WIDTH-1:0] fetch_word;

    bswb_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (fetch_en),
        .raddr (rd_addr),
        .rdata (fetch_word)
    );

    bswb_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (rd_start),
        .word_in   (fetch_word),
        .fetch_en  (fetch_en),
        .ser_bit   (ser_bit),
        .bit_valid (bit_valid),
        .busy      (busy),
        .done      (done)
    );

endmodule

// File: rtl/bswb_checker.sv
module bswb_checker #(
    parameter int WIDTH = 10
) (
    input logic clk,
    input logic rst,
    input logic rd_start,
    input logic ser_bit,
    input logic bit_valid,
    input logic busy,
    input logic done
);
    localparam int RW = $clog2(WIDTH + 1) + 1;

    logic [RW-1:0] run_q;

    // Counts valid cycles of the current read; cleared while idle.
    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            run_q <= '0;
        end else if (bit_valid) begin
            run_q <= run_q + 1'b1;
        end
    end

    p_valid_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> busy);

    p_accept_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_start && !busy) |=> (busy && !bit_valid));

    p_fetch_then_valid_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !bit_valid) |=> bit_valid);

    p_done_single_r4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !bit_valid));

    p_run_length_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_q == RW'(WIDTH)));

    p_zero_fill_r5: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |-> !ser_bit);

    p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && rd_start) |=> !(busy && !bit_valid));

endmodule

bind bitserial_word_buf bswb_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_start  (rd_start),
    .ser_bit   (ser_bit),
    .bit_valid (bit_valid),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_bitserial_word_buf.sv
module tb_bitserial_word_buf;
    localparam int W       = 10;
    localparam int D       = 256;
    localparam int AW      = 8;
    localparam int CLK_PER = 10;
    localparam int NVEC    = 6;
    localparam int WDOG    = 20000;

    // Table entries: {address, word}; each word is written, then read back serially.
    localparam logic [AW+W-1:0] VEC [NVEC] = '{
        {8'd0,   10'h2AA},
        {8'd1,   10'h155},
        {8'd255, 10'h3FF},
        {8'd17,  10'h001},
        {8'd128, 10'h200},
        {8'd64,  10'h0F3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_start = 1'b0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic ser_bit, bit_valid, busy, done;

    logic [W-1:0] shadow [D];
    int n_chk = 0, n_bad = 0;
    int cyc = 0;

    always #(CLK_PER/2) clk = ~clk;

    bitserial_word_buf #(.WIDTH(W), .DEPTH(D)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_start(rd_start), .rd_addr(rd_addr), .ser_bit(ser_bit),
        .bit_valid(bit_valid), .busy(busy), .done(done)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_word(input logic [AW-1:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0;
        shadow[a] = d;
    endtask

    // mode 0: plain; 1: strobe while busy (R6); 2: write same addr mid-run (R7);
    // 3: write same addr at the accepting edge (R7). Ends in the done cycle.
    task automatic read_word(input logic [AW-1:0] a, input int mode,
                             input logic [W-1:0] nd);
        logic [W-1:0] exp;
        exp = shadow[a];
        rd_start = 1'b1; rd_addr = a;
        if (mode == 3) begin
            wr_en = 1'b1; wr_addr = a; wr_data = nd;
        end
        step();
        rd_start = 1'b0;
        if (mode == 3) begin
            wr_en = 1'b0; shadow[a] = nd;
        end
        chk(busy && !bit_valid, "R2 fetch cycle", {busy, bit_valid}, 2'b10);
        step();
        for (int i = 0; i < W; i++) begin
            if (i == 3 && mode == 1) begin rd_start = 1'b1; rd_addr = a + 1'b1; end
            if (i == 3 && mode == 2) begin
                wr_en = 1'b1; wr_addr = a; wr_data = nd;
            end
            chk(bit_valid, "R3 valid window", bit_valid, 1);
            chk(ser_bit == exp[i], (mode >= 2) ? "R7 bit unaffected" : "R3 bit order",
                ser_bit, exp[i]);
            step();
            if (i == 3) begin
                rd_start = 1'b0;
                if (mode == 2) begin wr_en = 1'b0; shadow[a] = nd; end
            end
        end
        chk(done && !busy && !bit_valid, "R4 done cycle",
            {done, busy, bit_valid}, 3'b100);
        chk(!ser_bit, "R5 zero after run", ser_bit, 0);
    endtask

    initial begin
        for (int k = 0; k < D; k++) shadow[k] = '0;
        step(); step();
        rst = 1'b0;
        // R8 reset state
        chk(!busy && !bit_valid && !done && !ser_bit, "R8 reset state",
            {busy, bit_valid, done, ser_bit}, 0);
        // R1/R9: write all table words, including the top address
        for (int v = 0; v < NVEC; v++)
            write_word(VEC[v][AW+W-1:W], VEC[v][W-1:0]);
        // R3/R4: read back-to-back, each strobe issued in the done cycle
        for (int v = 0; v < NVEC; v++) begin
            read_word(VEC[v][AW+W-1:W], 0, '0);
            chk(shadow[VEC[v][AW+W-1:W]] == VEC[v][W-1:0], "R1 table word",
                shadow[VEC[v][AW+W-1:W]], VEC[v][W-1:0]);
        end
        step();
        chk(!busy && !done, "R4 idle after run", {busy, done}, 0);
        // R6 strobe while busy is ignored, nothing queued
        read_word(8'd1, 1, '0);
        step(); step(); step();
        chk(!busy && !bit_valid, "R6 no queued read", {busy, bit_valid}, 0);
        // R7 write during run, then new data on next read
        read_word(8'd0, 2, 10'h0C5);
        read_word(8'd0, 0, '0);
        // R7 write at accepting edge reads old word
        read_word(8'd17, 3, 10'h3A0);
        read_word(8'd17, 0, '0);
        // R8 reset mid-run keeps RAM
        rd_start = 1'b1; rd_addr = 8'd255;
        step(); rd_start = 1'b0;
        step(); step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk(!busy && !bit_valid && !done && !ser_bit, "R8 mid-run reset",
            {busy, bit_valid, done, ser_bit}, 0);
        read_word(8'd255, 0, '0);
        read_word(8'd128, 0, '0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WDOG) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule